// File: doc/BRIEF.md
# Storage Key Protection Checker

This block decides, in a single combinational pass, whether one memory access must be refused because of storage-key protection. It takes the logical address, the 4-bit access key of the requester, the 4-bit storage key of the addressed block with its fetch-protect bit, and a set of qualifiers. The qualifiers are a private-space flag, a page/list protect flag, a guest-mode flag, three enable bits and an extended-addressing mode select. It returns a violation flag and a 3-bit code naming the rule that decided the outcome.

Fetches and stores follow different rule chains. A store first meets low-address protection, which has a range that depends on the mode. It then meets the page/list protect flag, then the zero-key pass, then the key-9 override, and finally the plain key compare. A fetch is only refused by a fetch-protected storage key whose value differs from the access key. It can be rescued by a zero access key, by the low-storage fetch override, or by the key-9 override. The block has no clock and no state. The surrounding pipeline samples the result in the same cycle it presents the access.

Top module: `skey_prot_check`

## Requirements
- R1: A fetch (`is_store`=0) with access key 0 is never refused, whatever the storage key, fetch-protect bit and enables.
- R2: With `ctl_en[1]` (fetch override) set, a fetch from an address below 2048 in a non-private space is allowed regardless of the keys. This enable has no effect on stores.
- R3: With `ctl_en[2]` (key-9 override) set, an access to a block whose storage key equals 9 is allowed. For a store, this applies only after the low-address and page/list checks have passed.
- R4: When no earlier fetch rule allows the fetch, it is refused with reason 4 exactly when `fetch_prot` is 1 and the access key differs from the storage key. Otherwise it is allowed.
- R5: With `ext_mode`=0, the low-address range is addresses 0 to 511 inclusive.
- R6: With `ext_mode`=1, the low-address range is 0 to 511 and 4096 to 4607 inclusive. Every other address, including those with any bit above bit 12 set, is outside it.
- R7: Low-address protection refuses a store with reason 1 when the address is in range, `ctl_en[0]` is 1, `priv_space` is 0 and `guest` is 0. It never refuses a fetch.
- R8: A store not caught by R7 is refused with reason 2 whenever `page_prot` is 1, regardless of keys and overrides. `page_prot` has no effect on fetches.
- R9: A store that passes R7 and R8 is allowed when the access key is 0 or R3 applies. Otherwise it is refused with reason 3 when the access key differs from the storage key, and allowed when the keys match.
- R10: Reason encoding: 0 allowed, 1 low-address, 2 page/list, 3 store key mismatch, 4 fetch protection. `violation` is 1 exactly when the reason is nonzero.
- R11: Outputs depend only on the present inputs, so the result is valid in the cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 64 | Logical address of the access |
| acc_key | input | 4 | Access key of the requester |
| stor_key | input | 4 | Storage key of the addressed block |
| fetch_prot | input | 1 | Fetch-protect bit of the storage key |
| priv_space | input | 1 | Access targets a private address space |
| page_prot | input | 1 | Page or access-list protection applies |
| guest | input | 1 | Requester runs in guest mode |
| ctl_en | input | 3 | Enables: [0] low-address protect, [1] fetch override, [2] key-9 override |
| ext_mode | input | 1 | Extended-addressing mode (second low-address window) |
| is_store | input | 1 | Access type: 0 fetch, 1 store |
| violation | output | 1 | Access is refused |
| reason | output | 3 | Deciding rule code (see R10) |

## Verification
Both results are combinational, so they are due zero cycles after a stimulus. The bench changes inputs just after a rising clock edge and reads `violation` and `reason` at the following falling edge, when the logic has settled. No register lies on the path, so no cycle offset is added. An independent priority model in the bench supplies the expected code for every vector. The vectors are a full access-key by storage-key sweep plus a sweep of every qualifier over addresses that sit on each window edge.

// File: rtl/skp_pkg.sv
package skp_pkg;

    typedef enum logic [2:0] {
        RSN_OK        = 3'd0,
        RSN_LOWADDR   = 3'd1,
        RSN_PAGE      = 3'd2,
        RSN_KEYMIS    = 3'd3,
        RSN_FETCHPROT = 3'd4
    } reason_e;

    typedef struct packed {
        logic sovr_en;
        logic fovr_en;
        logic low_en;
    } ctl_t;

    function automatic logic keys_differ(input logic [3:0] a, input logic [3:0] b);
        return a != b;
    endfunction

endpackage

// File: rtl/skp_low_addr.sv
module skp_low_addr #(
    parameter int ADDR_W   = 64,
    parameter int LOW_SPAN = 512,
    parameter int ALT_BASE = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_mode,
    input  logic              low_en,
    input  logic              priv,
    input  logic              guest,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] PRI_END = ADDR_W'(LOW_SPAN);
    localparam logic [ADDR_W-1:0] ALT_LO  = ADDR_W'(ALT_BASE);
    localparam logic [ADDR_W-1:0] ALT_END = ADDR_W'(ALT_BASE + LOW_SPAN);

    logic in_pri, in_alt, in_range;

    always_comb begin
        in_pri   = addr < PRI_END;
        in_alt   = (addr >= ALT_LO) && (addr < ALT_END);
        in_range = in_pri | (ext_mode & in_alt);
        hit      = in_range & low_en & ~priv & ~guest;
    end

    always_comb begin
        if (hit) begin
            AST_LOW_NOT_PRIVATE: assert (!priv && !guest); // R7
        end
    end
endmodule

// File: rtl/skp_fetch_rule.sv
module skp_fetch_rule #(
    parameter int ADDR_W     = 64,
    parameter int KEY_W      = 4,
    parameter int FOVR_LIMIT = 2048,
    parameter int OVR_KEY    = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  akey,
    input  logic [KEY_W-1:0]  skey,
    input  logic              fp_bit,
    input  logic              priv,
    input  logic              fovr_en,
    input  logic              sovr_en,
    output logic              blocked
);
    import skp_pkg::*;
    localparam logic [ADDR_W-1:0] FOVR_END = ADDR_W'(FOVR_LIMIT);
    localparam logic [KEY_W-1:0]  KEY9     = KEY_W'(OVR_KEY);

    logic pass_zero, pass_fovr, pass_key9;

    always_comb begin
        pass_zero = akey == '0;
        pass_fovr = fovr_en && !priv && (addr < FOVR_END);
        pass_key9 = sovr_en && (skey == KEY9);
        if (pass_zero || pass_fovr || pass_key9)
            blocked = 1'b0;
        else
            blocked = fp_bit && keys_differ(akey, skey);
    end

    always_comb begin
        if (akey == '0) begin
            AST_FETCH_ZERO_KEY: assert (!blocked); // R1
        end
        if (!fp_bit) begin
            AST_FETCH_NEEDS_FP: assert (!blocked); // R4
        end
    end
endmodule

// File: rtl/skp_store_rule.sv
module skp_store_rule #(
    parameter int KEY_W   = 4,
    parameter int OVR_KEY = 9
) (
    input  logic              low_hit,
    input  logic              page_prot,
    input  logic [KEY_W-1:0]  akey,
    input  logic [KEY_W-1:0]  skey,
    input  logic              sovr_en,
    output logic              blocked,
    output skp_pkg::reason_e  rsn
);
    import skp_pkg::*;
    localparam logic [KEY_W-1:0] KEY9 = KEY_W'(OVR_KEY);

    always_comb begin
        if (low_hit) begin
            blocked = 1'b1;
            rsn     = RSN_LOWADDR;
        end else if (page_prot) begin
            blocked = 1'b1;
            rsn     = RSN_PAGE;
        end else if (akey == '0) begin
            blocked = 1'b0;
            rsn     = RSN_OK;
        end else if (sovr_en && (skey == KEY9)) begin
            blocked = 1'b0;
            rsn     = RSN_OK;
        end else if (keys_differ(akey, skey)) begin
            blocked = 1'b1;
            rsn     = RSN_KEYMIS;
        end else begin
            blocked = 1'b0;
            rsn     = RSN_OK;
        end
    end

    always_comb begin
        if (low_hit) begin
            AST_STORE_LOW_FIRST: assert (rsn == RSN_LOWADDR); // R7
        end
        if (!low_hit && page_prot) begin
            AST_STORE_PAGE_BLOCK: assert (blocked && rsn == RSN_PAGE); // R8
        end
        AST_STORE_NO_FP_CODE: assert (rsn != RSN_FETCHPROT); // R10
    end
endmodule

// File: rtl/skey_prot_check.sv
module skey_prot_check #(
    parameter int ADDR_W     = 64,
    parameter int KEY_W      = 4,
    parameter int LOW_SPAN   = 512,
    parameter int ALT_BASE   = 4096,
    parameter int FOVR_LIMIT = 2048,
    parameter int OVR_KEY    = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  acc_key,
    input  logic [KEY_W-1:0]  stor_key,
    input  logic              fetch_prot,
    input  logic              priv_space,
    input  logic              page_prot,
    input  logic              guest,
    input  logic [2:0]        ctl_en,
    input  logic              ext_mode,
    input  logic              is_store,
    output logic              violation,
    output logic [2:0]        reason
);
    import skp_pkg::*;

    ctl_t    ctl;
    logic    low_hit;
    logic    fe_blk;
    logic    st_blk;
    reason_e st_rsn;
    reason_e sel_rsn;

    assign ctl = ctl_t'(ctl_en);

    skp_low_addr #(
        .ADDR_W(ADDR_W), .LOW_SPAN(LOW_SPAN), .ALT_BASE(ALT_BASE)
    ) u_low (
        .addr(addr), .ext_mode(ext_mode), .low_en(ctl.low_en),
        .priv(priv_space), .guest(guest), .hit(low_hit)
    );

    skp_fetch_rule #(
        .ADDR_W(ADDR_W), .KEY_W(KEY_W), .FOVR_LIMIT(FOVR_LIMIT), .OVR_KEY(OVR_KEY)
    ) u_fetch (
        .addr(addr), .akey(acc_key), .skey(stor_key), .fp_bit(fetch_prot),
        .priv(priv_space), .fovr_en(ctl.fovr_en), .sovr_en(ctl.sovr_en),
        .blocked(fe_blk)
    );

    skp_store_rule #(
        .KEY_W(KEY_W), .OVR_KEY(OVR_KEY)
    ) u_store (
        .low_hit(low_hit), .page_prot(page_prot), .akey(acc_key),
        .skey(stor_key), .sovr_en(ctl.sovr_en), .blocked(st_blk), .rsn(st_rsn)
    );

    always_comb begin
        if (is_store) begin
            violation = st_blk;
            sel_rsn   = st_rsn;
        end else begin
            violation = fe_blk;
            sel_rsn   = fe_blk ? RSN_FETCHPROT : RSN_OK;
        end
        reason = sel_rsn;
    end

    always_comb begin
        AST_FLAG_MATCHES_CODE: assert (violation == (reason != 3'd0)); // R10
        if (!is_store) begin
            AST_FETCH_CODE_SET: assert (reason == 3'd0 || reason == 3'd4); // R7
        end
        if (!is_store && acc_key == '0) begin
            AST_TOP_FETCH_ZERO: assert (!violation); // R1
        end
    end
endmodule

// File: tb/skey_prot_check_test.sv
module skey_prot_check_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] addr = '0;
    logic [3:0]  acc_key = '0, stor_key = '0;
    logic        fetch_prot = 0, priv_space = 0, page_prot = 0, guest = 0;
    logic [2:0]  ctl_en = '0;
    logic        ext_mode = 0, is_store = 0;
    logic        violation;
    logic [2:0]  reason;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    skey_prot_check uut (
        .addr(addr), .acc_key(acc_key), .stor_key(stor_key), .fetch_prot(fetch_prot),
        .priv_space(priv_space), .page_prot(page_prot), .guest(guest),
        .ctl_en(ctl_en), .ext_mode(ext_mode), .is_store(is_store),
        .violation(violation), .reason(reason)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit in_low(input logic [63:0] a, input logic ext);
        if (a <= 64'd511) return 1;
        if (ext && a >= 64'd4096 && a <= 64'd4607) return 1;
        return 0;
    endfunction

    function automatic int model(input logic [63:0] a, input logic [3:0] ak,
                                 input logic [3:0] sk, input logic fp,
                                 input logic pv, input logic pg, input logic gu,
                                 input logic [2:0] en, input logic ext, input logic st);
        bit k9;
        k9 = en[2] && sk == 4'd9;
        if (st) begin
            if (in_low(a, ext) && en[0] && !pv && !gu) return 1;
            if (pg) return 2;
            if (ak == 0) return 0;
            if (k9) return 0;
            if (ak != sk) return 3;
            return 0;
        end
        if (ak == 0) return 0;
        if (en[1] && !pv && a < 64'd2048) return 0;
        if (k9) return 0;
        if (fp && ak != sk) return 4;
        return 0;
    endfunction

    function automatic string tag_for(input int r, input logic st, input logic [2:0] en);
        case (r)
            1: return "R7";
            2: return "R8";
            3: return "R9";
            4: return "R4";
            default: return st ? "R9/R3" : (en[1] ? "R2" : "R1/R4");
        endcase
    endfunction

    task automatic apply_check(input logic [63:0] a, input logic [3:0] ak,
                               input logic [3:0] sk, input logic fp, input logic pv,
                               input logic pg, input logic gu, input logic [2:0] en,
                               input logic ext, input logic st, input string tag);
        int exp;
        @(posedge clk);
        #1;
        addr = a; acc_key = ak; stor_key = sk; fetch_prot = fp; priv_space = pv;
        page_prot = pg; guest = gu; ctl_en = en; ext_mode = ext; is_store = st;
        exp = model(a, ak, sk, fp, pv, pg, gu, en, ext, st);
        @(negedge clk);
        checks = checks + 1;
        if (int'(reason) != exp || violation != (exp != 0)) begin
            errors = errors + 1;
            $display("FAIL %s (R10/R11) addr=%h ak=%0d sk=%0d fp=%0d pv=%0d pg=%0d gu=%0d en=%b ext=%0d st=%0d: actual reason=%0d viol=%0d expected reason=%0d viol=%0d",
                     tag, a, ak, sk, fp, pv, pg, gu, en, ext, st,
                     reason, violation, exp, exp != 0);
        end
    endtask

    logic [63:0] addrs [11];

    initial begin
        addrs[0] = 64'd0;    addrs[1] = 64'd511;  addrs[2] = 64'd512;
        addrs[3] = 64'd2047; addrs[4] = 64'd2048; addrs[5] = 64'd4095;
        addrs[6] = 64'd4096; addrs[7] = 64'd4607; addrs[8] = 64'd4608;
        addrs[9] = 64'h0000_0001_0000_0000;
        addrs[10] = 64'h1000_0000_0000_0100;

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle inputs after reset: allowed (R10, R11)
        @(negedge clk);
        checks = checks + 1;
        if (violation !== 1'b0 || reason !== 3'd0) begin
            errors = errors + 1;
            $display("FAIL R10 idle: actual viol=%0d reason=%0d expected viol=0 reason=0", violation, reason);
        end

        // Directed corner cases
        apply_check(64'd100, 4'd0, 4'd5, 1, 0, 0, 0, 3'b000, 0, 0, "R1");
        apply_check(64'd2047, 4'd3, 4'd5, 1, 0, 0, 0, 3'b010, 0, 0, "R2");
        apply_check(64'd2048, 4'd3, 4'd5, 1, 0, 0, 0, 3'b010, 0, 0, "R2");
        apply_check(64'd1000, 4'd3, 4'd5, 0, 0, 0, 0, 3'b010, 0, 1, "R2");
        apply_check(64'd8000, 4'd3, 4'd9, 1, 0, 0, 0, 3'b100, 0, 0, "R3");
        apply_check(64'd8000, 4'd3, 4'd9, 0, 0, 0, 0, 3'b100, 0, 1, "R3");
        apply_check(64'd511, 4'd0, 4'd0, 0, 0, 0, 0, 3'b001, 0, 1, "R5");
        apply_check(64'd512, 4'd0, 4'd0, 0, 0, 0, 0, 3'b001, 0, 1, "R5");
        apply_check(64'd4096, 4'd0, 4'd0, 0, 0, 0, 0, 3'b001, 1, 1, "R6");
        apply_check(64'd4607, 4'd0, 4'd0, 0, 0, 0, 0, 3'b001, 0, 1, "R6");
        apply_check(64'd4608, 4'd0, 4'd0, 0, 0, 0, 0, 3'b001, 1, 1, "R6");
        apply_check(64'd10, 4'd0, 4'd0, 0, 0, 0, 1, 3'b001, 0, 1, "R7");
        apply_check(64'd10, 4'd0, 4'd0, 0, 0, 1, 0, 3'b111, 0, 1, "R8");
        apply_check(64'd9000, 4'd6, 4'd6, 0, 0, 0, 0, 3'b000, 0, 1, "R9");

        // Full key sweep, plain compare
        for (int st = 0; st < 2; st++)
            for (int ak = 0; ak < 16; ak++)
                for (int sk = 0; sk < 16; sk++)
                    for (int fp = 0; fp < 2; fp++)
                        apply_check(64'd9000, 4'(ak), 4'(sk), 1'(fp), 0, 0, 0, 3'b000, 0,
                                    1'(st), st ? "R9" : "R4");

        // Qualifier sweep over window edges
        for (int st = 0; st < 2; st++)
            for (int ai = 0; ai < 11; ai++)
                for (int en = 0; en < 8; en++)
                    for (int q = 0; q < 16; q++)
                        for (int ki = 0; ki < 3; ki++)
                            for (int si = 0; si < 3; si++) begin
                                logic [3:0] ak, sk;
                                int e;
                                ak = (ki == 0) ? 4'd0 : (ki == 1) ? 4'd5 : 4'd9;
                                sk = (si == 0) ? 4'd5 : (si == 1) ? 4'd9 : 4'd12;
                                e = model(addrs[ai], ak, sk, 1, q[0], q[1], q[2], 3'(en), q[3], 1'(st));
                                apply_check(addrs[ai], ak, sk, 1, q[0], q[1], q[2], 3'(en), q[3],
                                            1'(st), tag_for(e, 1'(st), 3'(en)));
                            end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule